// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

This block drives four pulse-width modulated outputs from one input clock. Each pair of channels shares an 8-bit clock prescaler; behind it every channel has its own power-of-two clock selector, a 16-bit counter that runs from zero up to a programmed period value, and a 16-bit compare value that sets how long the output stays high in each period. Software sets everything through a small 32-bit register bus with a single write strobe and a read path that decodes the address.

A channel runs when it is enabled and its period value is non-zero. Continuous mode repeats the period without end. One-shot mode produces a single high pulse and then holds the pin low until the channel is disabled. An invert bit complements the running waveform. Period and compare values written while a channel runs are held back until the current period ends. Each channel raises a status flag at every period end, and a mask register decides which flags reach the interrupt output.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads 0, every `pwm_out` bit is low and `irq` is low.
- R2: Register offsets are: prescale 0x00, selector 0x04, control 0x08, interrupt enable 0x3C, interrupt status 0x40, and period/compare for channel n at 0x0C+12n and 0x10+12n (16 bits each). The control field of channels 0..3 starts at bit 0, 8, 12 and 16. Inside a field, bit 0 enables, bit 2 inverts and bit 3 selects continuous mode. Selector fields are 3 bits wide at bit 4n. Unused bits read 0.
- R3: Prescale bits [7:0] serve channels 0 and 1 and bits [15:8] serve channels 2 and 3. Each field value F divides the clock by F+1.
- R4: Selector codes 0, 1, 2 and 3 divide by 2, 4, 8 and 16. Code 4, and the unused codes 5 to 7, divide by 1.
- R5: In continuous mode the output period is (F+1)·D·(P+1) clocks. When the compare value C is below P, the output is high for (F+1)·D·(C+1) clocks at the start of each period.
- R6: When C ≥ P the running output stays high without a break.
- R7: A period value of 0 stops the channel and its output stays low.
- R8: With the invert bit set, a running channel outputs the complement of its waveform.
- R9: In one-shot mode, enabling the channel gives exactly one high pulse of (F+1)·D·(C+1) clocks. The output then stays low until the enable is cleared.
- R10: A period or compare write made while a channel runs takes effect only at the next period boundary.
- R11: Each channel's status flag sets at the end of every period. Writing 1 to its bit at 0x40 clears it. `irq` is the OR of the flags that have their enable bit set at 0x3C.
- R12: A disabled channel outputs low, whatever its mode and period are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counters |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, decoded from `bus_addr` in the same cycle |
| pwm_out | output | 4 | One modulated output per channel |
| irq | output | 1 | Interrupt, the OR of the enabled status flags |

## Verification
A register write lands at the clock edge where `bus_we` is high, so read data reflects it one cycle later. A control write that starts a channel loads the active period and compare on the next edge, and the registered pin follows one edge after that, two cycles in all. A status flag rises one cycle after the period end and `irq` follows combinationally. The prescaler and selector run freely, so the phase of the first period is not fixed. The bench therefore ignores the first period and measures the lengths of later high and low stretches on the falling edge. A boundary-load check writes the compare value just after the output falls and expects the remaining low time of that period to be unchanged.

// File: rtl/pwm_quad_pkg.sv
// Package: shared widths, register offsets and control field type for the
// four-channel modulator. Assumes exactly four channels in two pairs.
package pwm_quad_pkg;
    localparam int NCH      = 4;
    localparam int NPAIR    = NCH / 2;
    localparam int PRE_W    = 8;
    localparam int SEL_W    = 3;
    localparam int SEL_STEP = 4;
    localparam int CNT_W    = 16;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int DIV_W    = 4;
    localparam int CH_STRIDE = 12;

    localparam logic [ADDR_W-1:0] A_PRE  = 8'h00;
    localparam logic [ADDR_W-1:0] A_SEL  = 8'h04;
    localparam logic [ADDR_W-1:0] A_CTL  = 8'h08;
    localparam logic [ADDR_W-1:0] A_PER0 = 8'h0C;
    localparam logic [ADDR_W-1:0] A_IEN  = 8'h3C;
    localparam logic [ADDR_W-1:0] A_IST  = 8'h40;

    typedef struct packed {
        logic cont;
        logic inv;
        logic en;
    } chan_ctl_t;

    // Bit position of a channel's control field (fields are not evenly spaced)
    function automatic int ctl_lsb(input int ch);
        return (ch == 0) ? 0 : (4 + 4 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] per_addr(input int ch);
        return A_PER0 + ADDR_W'(CH_STRIDE * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_addr(input int ch);
        return per_addr(ch) + ADDR_W'(4);
    endfunction
endpackage

// File: rtl/pwm_quad_regs.sv
// Register file: holds all configuration, the per-channel status flags and
// the interrupt mask, and serves the read mux. Assumes single-cycle writes.
module pwm_quad_regs
    import pwm_quad_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_we,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    input  logic [NCH-1:0]                   roll,
    output logic [NPAIR-1:0][PRE_W-1:0]      pre_f,
    output logic [NCH-1:0][SEL_W-1:0]        sel_f,
    output chan_ctl_t [NCH-1:0]              ctl_f,
    output logic [NCH-1:0][CNT_W-1:0]        per_f,
    output logic [NCH-1:0][CNT_W-1:0]        cmp_f,
    output logic [NCH-1:0]                   irq_flag,
    output logic [NCH-1:0]                   irq_en
);
    logic sig_unused;
    assign sig_unused = ^bus_wdata;

    // Configuration registers: captured on a matching write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_f  <= '0;
            sel_f  <= '0;
            ctl_f  <= '0;
            per_f  <= '0;
            cmp_f  <= '0;
            irq_en <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_PRE)
                for (int p = 0; p < NPAIR; p++)
                    pre_f[p] <= bus_wdata[p*PRE_W +: PRE_W];
            if (bus_addr == A_SEL)
                for (int i = 0; i < NCH; i++)
                    sel_f[i] <= bus_wdata[SEL_STEP*i +: SEL_W];
            if (bus_addr == A_CTL)
                for (int i = 0; i < NCH; i++) begin
                    ctl_f[i].en   <= bus_wdata[ctl_lsb(i)];
                    ctl_f[i].inv  <= bus_wdata[ctl_lsb(i) + 2];
                    ctl_f[i].cont <= bus_wdata[ctl_lsb(i) + 3];
                end
            if (bus_addr == A_IEN)
                irq_en <= bus_wdata[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == per_addr(i)) per_f[i] <= bus_wdata[CNT_W-1:0];
                if (bus_addr == cmp_addr(i)) cmp_f[i] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // Status flags: set on period end (wins), cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (roll[i])
                    irq_flag[i] <= 1'b1;
                else if (bus_we && bus_addr == A_IST && bus_wdata[i])
                    irq_flag[i] <= 1'b0;
            end
        end
    end

    // Read mux: unmapped addresses and unused bits return zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_PRE: for (int p = 0; p < NPAIR; p++) bus_rdata[p*PRE_W +: PRE_W] = pre_f[p];
            A_SEL: for (int i = 0; i < NCH; i++) bus_rdata[SEL_STEP*i +: SEL_W] = sel_f[i];
            A_CTL: for (int i = 0; i < NCH; i++) begin
                       bus_rdata[ctl_lsb(i)]     = ctl_f[i].en;
                       bus_rdata[ctl_lsb(i) + 2] = ctl_f[i].inv;
                       bus_rdata[ctl_lsb(i) + 3] = ctl_f[i].cont;
                   end
            A_IEN: bus_rdata[NCH-1:0] = irq_en;
            A_IST: bus_rdata[NCH-1:0] = irq_flag;
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == per_addr(i)) bus_rdata[CNT_W-1:0] = per_f[i];
            if (bus_addr == cmp_addr(i)) bus_rdata[CNT_W-1:0] = cmp_f[i];
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_flag_chk
            // R11: a period end always leaves the flag set
            p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
                roll[g] |=> irq_flag[g]);
            // R11: a clearing write with no period end drops the flag
            p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && bus_addr == A_IST && bus_wdata[g] && !roll[g]) |=> !irq_flag[g]);
        end
    endgenerate
endmodule

// File: rtl/pwm_quad_presc.sv
// Prescaler shared by one channel pair: pulses tick once every field+1
// clocks. Free running; a lowered field takes effect within one wrap.
module pwm_quad_presc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] field,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = (cnt >= field);

    // Count up and wrap at the programmed field value
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/pwm_quad_chan.sv
// One channel: power-of-two selector on the pair tick, period counter with
// shadowed period/compare, one-shot or continuous run, invert and a
// registered output. Assumes pre_tick is a single-cycle pulse.
module pwm_quad_chan
    import pwm_quad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick,
    input  logic [SEL_W-1:0] sel_code,
    input  chan_ctl_t        ctl,
    input  logic [CNT_W-1:0] per_sh,
    input  logic [CNT_W-1:0] cmp_sh,
    output logic             pwm_q,
    output logic             roll
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_mask;
    logic             sel_tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_a;
    logic [CNT_W-1:0] cmp_a;
    logic             done;
    logic             run;

    // Selector code to divide mask: 0..3 -> /2../16, everything else -> /1
    always_comb begin
        case (sel_code)
            3'd0:    div_mask = 4'b0001;
            3'd1:    div_mask = 4'b0011;
            3'd2:    div_mask = 4'b0111;
            3'd3:    div_mask = 4'b1111;
            default: div_mask = 4'b0000;
        endcase
    end

    assign sel_tick = pre_tick && ((div_cnt & div_mask) == div_mask);
    assign run      = ctl.en && !done && (per_a != '0);
    assign roll     = run && sel_tick && (cnt == per_a);

    // Selector divider: free-running count of prescaler ticks
    always_ff @(posedge clk) begin
        if (!rst_n)        div_cnt <= '0;
        else if (pre_tick) div_cnt <= div_cnt + DIV_W'(1);
    end

    // Period counter with shadow load when idle or at the period end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            per_a <= '0;
            cmp_a <= '0;
            done  <= 1'b0;
        end else begin
            if (!ctl.en) done <= 1'b0;
            if (!run) begin
                cnt   <= '0;
                per_a <= per_sh;
                cmp_a <= cmp_sh;
            end else if (sel_tick) begin
                if (cnt == per_a) begin
                    cnt   <= '0;
                    per_a <= per_sh;
                    cmp_a <= cmp_sh;
                    if (!ctl.cont) done <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    // Registered pin: compare window, optionally inverted, low when stopped
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= run ? ((cnt <= cmp_a) ^ ctl.inv) : 1'b0;
    end

    // R5: a running counter never passes the active period
    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= per_a));
    // R7 / R12: a stopped or disabled channel drives low on the next edge
    p_stopped_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pwm_q);
    // R10: active values only change at a period end while running
    p_hold_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !roll) |=> ($stable(per_a) && $stable(cmp_a)));
    // R9: once the single period completes the pin goes low
    p_oneshot_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |=> !pwm_q);
endmodule

// File: rtl/pwm_quad.sv
// Top: four-channel pulse-width modulator with a shared prescaler per
// channel pair and a simple register bus. Assumes a single clock domain.
module pwm_quad
    import pwm_quad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out,
    output logic              irq
);
    logic [NPAIR-1:0][PRE_W-1:0] pre_f;
    logic [NCH-1:0][SEL_W-1:0]   sel_f;
    chan_ctl_t [NCH-1:0]         ctl_f;
    logic [NCH-1:0][CNT_W-1:0]   per_f;
    logic [NCH-1:0][CNT_W-1:0]   cmp_f;
    logic [NCH-1:0]              irq_flag;
    logic [NCH-1:0]              irq_en;
    logic [NCH-1:0]              roll;
    logic [NPAIR-1:0]            pre_tick;

    pwm_quad_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .roll      (roll),
        .pre_f     (pre_f),
        .sel_f     (sel_f),
        .ctl_f     (ctl_f),
        .per_f     (per_f),
        .cmp_f     (cmp_f),
        .irq_flag  (irq_flag),
        .irq_en    (irq_en)
    );

    generate
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            pwm_quad_presc #(.W(PRE_W)) u_presc (
                .clk   (clk),
                .rst_n (rst_n),
                .field (pre_f[p]),
                .tick  (pre_tick[p])
            );
        end
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            pwm_quad_chan u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .pre_tick (pre_tick[c/2]),
                .sel_code (sel_f[c]),
                .ctl      (ctl_f[c]),
                .per_sh   (per_f[c]),
                .cmp_sh   (cmp_f[c]),
                .pwm_q    (pwm_out[c]),
                .roll     (roll[c])
            );
        end
    endgenerate

    assign irq = |(irq_flag & irq_en);

    // R1: out of reset no pin and no interrupt is active
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0 && !irq));
endmodule

// File: tb/pwm_quad_tb.sv
module pwm_quad_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pwm_quad u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq)
    );

    localparam int CTL_POS[4] = '{0, 8, 12, 16};
    localparam int NV = 6;
    localparam int V_CH[NV]  = '{0, 1, 2, 3, 0, 3};
    localparam int V_PRE[NV] = '{0, 1, 2, 0, 0, 3};
    localparam int V_SEL[NV] = '{4, 0, 1, 2, 3, 7};
    localparam int V_PER[NV] = '{9, 4, 3, 2, 1, 5};
    localparam int V_CMP[NV] = '{3, 1, 0, 1, 0, 2};
    localparam int V_EP[NV]  = '{10, 20, 48, 24, 32, 24};
    localparam int V_EH[NV]  = '{4, 8, 12, 16, 16, 12};

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_lvl(input int ch, input logic lvl);
        while (pwm_out[ch] !== lvl) @(negedge clk);
    endtask

    // Skip the first period, then measure high time and full period
    task automatic measure(input int ch, output int per, output int hi);
        @(negedge clk);
        wait_lvl(ch, 1'b1); wait_lvl(ch, 1'b0); wait_lvl(ch, 1'b1);
        hi = 0;
        while (pwm_out[ch] === 1'b1) begin hi++; @(negedge clk); end
        per = hi;
        while (pwm_out[ch] === 1'b0) begin per++; @(negedge clk); end
    endtask

    task automatic count_high(input int ch, input int n, output int hi, output int rises);
        logic prev;
        hi = 0; rises = 0; prev = pwm_out[ch];
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
            if (pwm_out[ch] && !prev) rises++;
            prev = pwm_out[ch];
        end
    endtask

    task automatic setup(input int ch, input int pre, input int sel, input int per,
                         input int cmp, input logic [3:0] bits);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'(pre) << (8 * (ch / 2)));
        wr(8'h04, 32'(sel) << (4 * ch));
        wr(8'(12 + 12 * ch), 32'(per));
        wr(8'(16 + 12 * ch), 32'(cmp));
        wr(8'h08, 32'(bits) << CTL_POS[ch]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int per, hi, rises, lowc;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check("R1 pwm_out", pwm_out, 0);
        check("R1 irq", irq, 0);
        rd(8'h00, d); check("R1 prescale", d, 0);
        rd(8'h08, d); check("R1 control", d, 0);
        rd(8'h0C, d); check("R1 period0", d, 0);

        // R2: readback with unused bits masked
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R2 prescale", d, 32'h0000_FFFF);
        wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); check("R2 selector", d, 32'h0000_7777);
        wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, d); check("R2 period3", d, 32'h0000_FFFF);
        wr(8'h28, 32'h1234_5678); rd(8'h28, d); check("R2 compare2", d, 32'h0000_5678);
        wr(8'h3C, 32'hFFFF_FFFF); rd(8'h3C, d); check("R2 irq enable", d, 32'hF);
        wr(8'h30, 0); wr(8'h28, 0); wr(8'h3C, 0);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); check("R2 control", d, 32'h000D_DD0D);
        wr(8'h08, 0);

        // R3 R4 R5: vector table
        for (int v = 0; v < NV; v++) begin
            setup(V_CH[v], V_PRE[v], V_SEL[v], V_PER[v], V_CMP[v], 4'b1001);
            measure(V_CH[v], per, hi);
            check($sformatf("R5 R4 R3 period vec%0d", v), per, V_EP[v]);
            check($sformatf("R5 R4 R3 high vec%0d", v), hi, V_EH[v]);
        end

        // R3: one prescale field shared by channels 0 and 1
        wr(8'h08, 0);
        wr(8'h00, 32'h0000_0001);
        wr(8'h04, 32'h0000_0444);
        wr(8'h18, 4); wr(8'h1C, 1);
        wr(8'h24, 4); wr(8'h28, 1);
        wr(8'h08, 32'h0000_9900);
        measure(1, per, hi); check("R3 pair0 period", per, 10);
        measure(2, per, hi); check("R3 pair1 period", per, 5);

        // R6: compare at and above period -> constant high
        setup(0, 0, 4, 5, 5, 4'b1001);
        repeat (6) @(negedge clk);
        count_high(0, 40, hi, rises); check("R6 cmp==per", hi, 40);
        wr(8'h10, 9); repeat (10) @(negedge clk);
        count_high(0, 40, hi, rises); check("R6 cmp>per", hi, 40);

        // R7: period zero stops the channel
        setup(0, 0, 4, 0, 3, 4'b1001);
        repeat (4) @(negedge clk);
        count_high(0, 40, hi, rises); check("R7 period zero", hi, 0);

        // R8: invert
        setup(0, 0, 4, 9, 3, 4'b1101);
        measure(0, per, hi);
        check("R8 inverted period", per, 10);
        check("R8 inverted high", hi, 6);

        // R12: disabled channel stays low
        setup(0, 0, 4, 9, 3, 4'b1000);
        count_high(0, 40, hi, rises); check("R12 disabled", hi, 0);

        // R9: one-shot gives a single pulse
        setup(0, 0, 4, 9, 3, 4'b0001);
        count_high(0, 60, hi, rises);
        check("R9 one-shot high", hi, 4);
        check("R9 one-shot rises", rises, 1);

        // R10: compare written mid-period applies at the next boundary
        setup(0, 0, 4, 9, 3, 4'b1001);
        @(negedge clk);
        wait_lvl(0, 1'b1); wait_lvl(0, 1'b0);
        lowc = 1;
        bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 32'd7;
        @(negedge clk);
        bus_we = 1'b0;
        while (pwm_out[0] === 1'b0) begin lowc++; @(negedge clk); end
        check("R10 old period low", lowc, 6);
        hi = 0;
        while (pwm_out[0] === 1'b1) begin hi++; @(negedge clk); end
        check("R10 new high", hi, 8);

        // R11: flags, mask and write-one-to-clear
        wr(8'h08, 0); wr(8'h40, 32'hF); wr(8'h3C, 0);
        rd(8'h40, d); check("R11 cleared", d, 0);
        setup(0, 0, 4, 9, 3, 4'b1001);
        repeat (25) @(negedge clk);
        rd(8'h40, d); check("R11 flag set", d & 32'h1, 1);
        check("R11 masked irq", irq, 0);
        wr(8'h3C, 32'h1);
        check("R11 irq enabled", irq, 1);
        wr(8'h08, 0); wr(8'h40, 32'h1);
        rd(8'h40, d); check("R11 flag clear", d, 0);
        check("R11 irq dropped", irq, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule